// File: doc/BRIEF.md
# Microword-Driven Pointer Register File

This block holds sixteen 16-bit registers. Two fields of a control word drive it on every clock. The first field is a 3-bit source selector. It decides which register is addressed: a fixed register (0, 1 or 2), or one of three 4-bit pointer inputs called X, N and P. The second field is a 3-bit update operation. It decides what is written back into the addressed register at the next rising edge.

The update can leave the register alone, clear it, step it up or down by one, or merge an 8-bit Y value into either its upper or its lower byte. It can also load the full 16-bit bus input. The addressed register is always visible on the read output as a combinational value, so the same microword both reads the old contents and writes the new ones.

A sequencer uses the block by driving the two fields straight from its microword. The default encoding of both fields (selector 0, update 0) is a no-op. Because of this, microinstructions that do not touch the register file need no extra field logic.

Top module: `ucode_regfile`

## Requirements
- R1: While rst_ni is low, every register is cleared to 0x0000 asynchronously.
- R2: Selector encoding: 0 selects register 0, 1 selects register 1, 2 selects register 2, 3 selects register X, 4 selects register N, 5 selects register P. Codes 6 and 7 select register 0. rd_data_o combinationally shows the selected register's current contents.
- R3: Update code 0 (hold) and the unused code 7 change no register, whatever the selector is.
- R4: Update code 1 writes 0x0000 into the selected register.
- R5: Update code 2 writes the old value plus one, wrapping 0xFFFF to 0x0000.
- R6: Update code 3 writes the old value minus one, wrapping 0x0000 to 0xFFFF.
- R7: Update code 4 writes Y into bits 15:8 and keeps bits 7:0.
- R8: Update code 5 writes Y into bits 7:0 and keeps bits 15:8.
- R9: Update code 6 writes bus_i into the selected register.
- R10: A write changes only the selected register. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_sel_i | input | 3 | Address source selector field |
| upd_op_i | input | 3 | Update operation field |
| ptr_x_i | input | 4 | X pointer |
| ptr_n_i | input | 4 | N pointer |
| ptr_p_i | input | 4 | P pointer |
| y_i | input | 8 | Byte operand for the merge operations |
| bus_i | input | 16 | Word for the bus-load operation |
| rd_data_o | output | 16 | Selected register contents |

## Verification
The bench goes after the wrap points. It increments 0xFFFF and decrements 0x0000. A carry-out-of-range bug or a missing borrow would leave 0x0000 or 0xFFFF wrong, or would corrupt a neighbour width.

It targets the unused codes. If selector 6/7 decoded as an X or P alias, or if update 7 wrote, the bench sees a changed register or a wrong read. It also checks both byte merges with patterns whose halves differ, so swapped byte lanes show up at once.

Full sweeps of all sixteen registers after writes and random traffic catch a write-enable that leaks into an unselected register.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [2:0] {
    SEL_ZERO = 3'd0,
    SEL_ONE  = 3'd1,
    SEL_TWO  = 3'd2,
    SEL_X    = 3'd3,
    SEL_N    = 3'd4,
    SEL_P    = 3'd5,
    SEL_U6   = 3'd6,
    SEL_U7   = 3'd7
  } addr_sel_e;

  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_CLR   = 3'd1,
    OP_INC   = 3'd2,
    OP_DEC   = 3'd3,
    OP_YHI   = 3'd4,
    OP_YLO   = 3'd5,
    OP_BUS   = 3'd6,
    OP_U7    = 3'd7
  } upd_op_e;
endpackage

// File: rtl/rf_addr_mux.sv
module rf_addr_mux
  import rf_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic [2:0]       sel_i,
  input  logic [PTR_W-1:0] ptr_x_i,
  input  logic [PTR_W-1:0] ptr_n_i,
  input  logic [PTR_W-1:0] ptr_p_i,
  output logic [PTR_W-1:0] idx_o
);
  always_comb begin
    unique case (addr_sel_e'(sel_i))
      SEL_ONE: idx_o = PTR_W'(1);
      SEL_TWO: idx_o = PTR_W'(2);
      SEL_X:   idx_o = ptr_x_i;
      SEL_N:   idx_o = ptr_n_i;
      SEL_P:   idx_o = ptr_p_i;
      default: idx_o = '0;  // zero, and unused 6/7
    endcase
  end
endmodule

// File: rtl/rf_next_val.sv
module rf_next_val
  import rf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [BYTE_W-1:0] y_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              we_o,
  output logic [DATA_W-1:0] nxt_o
);
  localparam int HI_W = DATA_W - BYTE_W;

  always_comb begin
    we_o  = 1'b1;
    nxt_o = old_i;
    unique case (upd_op_e'(op_i))
      OP_CLR: nxt_o = '0;
      OP_INC: nxt_o = old_i + DATA_W'(1);
      OP_DEC: nxt_o = old_i - DATA_W'(1);
      OP_YHI: nxt_o = {y_i, old_i[HI_W-1:0]};
      OP_YLO: nxt_o = {old_i[DATA_W-1:BYTE_W], y_i};
      OP_BUS: nxt_o = bus_i;
      default: we_o = 1'b0;  // hold, unused 7
    endcase
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [IDX_W-1:0]                  idx_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]   regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    assign hit = we_i && (idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  regs_o[g] <= '0;
      else if (hit) regs_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/ucode_regfile.sv
module ucode_regfile #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 16,
  parameter int BYTE_W   = 8,
  localparam int PTR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        addr_sel_i,
  input  logic [2:0]        upd_op_i,
  input  logic [PTR_W-1:0]  ptr_x_i,
  input  logic [PTR_W-1:0]  ptr_n_i,
  input  logic [PTR_W-1:0]  ptr_p_i,
  input  logic [BYTE_W-1:0] y_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [PTR_W-1:0]                rd_idx;
  logic                            wr_en;
  logic [DATA_W-1:0]               wr_data;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  rf_addr_mux #(.PTR_W(PTR_W)) u_addr (
    .sel_i   (addr_sel_i),
    .ptr_x_i (ptr_x_i),
    .ptr_n_i (ptr_n_i),
    .ptr_p_i (ptr_p_i),
    .idx_o   (rd_idx)
  );

  assign rd_data_o = regs_q[rd_idx];

  rf_next_val #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_nxt (
    .op_i  (upd_op_i),
    .old_i (rd_data_o),
    .y_i   (y_i),
    .bus_i (bus_i),
    .we_o  (wr_en),
    .nxt_o (wr_data)
  );

  rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en),
    .idx_i   (rd_idx),
    .wdata_i (wr_data),
    .regs_o  (regs_q)
  );
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 16,
  parameter int BYTE_W   = 8,
  localparam int PTR_W   = $clog2(NUM_REGS)
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [2:0]                      addr_sel_i,
  input logic [2:0]                      upd_op_i,
  input logic [PTR_W-1:0]                ptr_x_i,
  input logic [PTR_W-1:0]                ptr_n_i,
  input logic [PTR_W-1:0]                ptr_p_i,
  input logic [BYTE_W-1:0]               y_i,
  input logic [DATA_W-1:0]               bus_i,
  input logic [DATA_W-1:0]               rd_data_o,
  input logic [PTR_W-1:0]                idx_i,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs_i
);
  assert_idx_p_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_sel_i == 3'd5) |-> (idx_i == ptr_p_i));
  assert_idx_unused_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_sel_i[2:1] == 2'b11) |-> (idx_i == '0));
  assert_rd_matches_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o == regs_i[idx_i]);
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_op_i == 3'd0 || upd_op_i == 3'd7) |=> $stable(regs_i));
  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_op_i == 3'd1) |=> (regs_i[$past(idx_i)] == '0));
  assert_inc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_op_i == 3'd2) |=> (regs_i[$past(idx_i)] == DATA_W'($past(rd_data_o) + 1)));
  assert_dec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_op_i == 3'd3) |=> (regs_i[$past(idx_i)] == DATA_W'($past(rd_data_o) - 1)));
  assert_yhi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_op_i == 3'd4) |=> (regs_i[$past(idx_i)] ==
      {$past(y_i), $past(rd_data_o[DATA_W-BYTE_W-1:0])}));
  assert_ylo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_op_i == 3'd5) |=> (regs_i[$past(idx_i)] ==
      {$past(rd_data_o[DATA_W-1:BYTE_W]), $past(y_i)}));
  assert_bus_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_op_i == 3'd6) |=> (regs_i[$past(idx_i)] == $past(bus_i)));
endmodule

bind ucode_regfile rf_checker #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W),
  .BYTE_W   (BYTE_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_sel_i (addr_sel_i),
  .upd_op_i   (upd_op_i),
  .ptr_x_i    (ptr_x_i),
  .ptr_n_i    (ptr_n_i),
  .ptr_p_i    (ptr_p_i),
  .y_i        (y_i),
  .bus_i      (bus_i),
  .rd_data_o  (rd_data_o),
  .idx_i      (rd_idx),
  .regs_i     (regs_q)
);

// File: tb/tb_ucode_regfile.sv
`timescale 1ns/1ps
module tb_ucode_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  sel = '0, op = '0;
  logic [3:0]  px = '0, pn = '0, pp = '0;
  logic [7:0]  y = '0;
  logic [15:0] bus = '0;
  logic [15:0] rd;

  logic [15:0] model [16];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ucode_regfile dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_sel_i(sel), .upd_op_i(op),
    .ptr_x_i(px), .ptr_n_i(pn), .ptr_p_i(pp), .y_i(y), .bus_i(bus),
    .rd_data_o(rd)
  );

  function automatic logic [3:0] exp_idx(logic [2:0] s, logic [3:0] x, logic [3:0] n, logic [3:0] p);
    case (s)
      3'd1: return 4'd1;
      3'd2: return 4'd2;
      3'd3: return x;
      3'd4: return n;
      3'd5: return p;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [15:0] exp_val(logic [2:0] o, logic [15:0] v, logic [7:0] yy, logic [15:0] b);
    case (o)
      3'd1: return 16'h0000;
      3'd2: return v + 16'd1;
      3'd3: return v - 16'd1;
      3'd4: return {yy, v[7:0]};
      3'd5: return {v[15:8], yy};
      3'd6: return b;
      default: return v;
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one microword: drive after negedge, check read, apply at posedge
  task automatic step(string req, logic [2:0] s, logic [2:0] o, logic [3:0] x,
                      logic [3:0] n, logic [3:0] p, logic [7:0] yy, logic [15:0] b);
    logic [3:0] i;
    @(negedge clk);
    sel = s; op = o; px = x; pn = n; pp = p; y = yy; bus = b;
    i = exp_idx(s, x, n, p);
    #1 check(req, rd, model[i]);
    @(posedge clk);
    model[i] = exp_val(o, model[i], yy, b);
  endtask

  task automatic sweep(string req);
    for (int k = 0; k < 16; k++) step(req, 3'd3, 3'd0, 4'(k), 4'd0, 4'd0, 8'h00, 16'h0000);
  endtask

  // read one register through X with hold and compare against a literal
  task automatic peek(string req, logic [3:0] r, logic [15:0] exp);
    @(negedge clk);
    sel = 3'd3; op = 3'd0; px = r;
    #1 check(req, rd, exp);
  endtask

  initial begin
    for (int k = 0; k < 16; k++) model[k] = 16'h0;
    #12 rst_n = 1'b1;
    sweep("R1 reset value");

    // R9 bus load into several registers, R10 neighbours untouched
    step("R9", 3'd0, 3'd6, 0, 0, 0, 8'h00, 16'hA5C3);
    step("R9", 3'd3, 3'd6, 4'd9, 0, 0, 8'h00, 16'h1234);
    peek("R9 bus load", 4'd9, 16'h1234);
    step("R9", 3'd1, 3'd6, 0, 0, 0, 8'h00, 16'hFFFF);
    step("R9", 3'd2, 3'd6, 0, 0, 0, 8'h00, 16'h00FF);
    sweep("R10 isolation");

    // R4 clear on register 2
    step("R4", 3'd2, 3'd1, 0, 0, 0, 8'h00, 16'h0000);
    peek("R4 clear", 4'd2, 16'h0000);

    // R5 increment via P, wrap at 0xFFFF
    step("R5", 3'd5, 3'd6, 0, 0, 4'd7, 8'h00, 16'hFFFE);
    step("R5", 3'd5, 3'd2, 0, 0, 4'd7, 8'h00, 16'h0000);
    peek("R5 inc", 4'd7, 16'hFFFF);
    step("R5", 3'd5, 3'd2, 0, 0, 4'd7, 8'h00, 16'h0000);
    peek("R5 wrap", 4'd7, 16'h0000);

    // R6 decrement via N, wrap at 0x0000
    step("R6", 3'd4, 3'd3, 0, 4'd7, 0, 8'h00, 16'h0000);
    peek("R6 wrap", 4'd7, 16'hFFFF);

    // R7 / R8 byte merges on distinct halves
    step("R7", 3'd4, 3'd6, 0, 4'd12, 0, 8'h00, 16'h3C5A);
    step("R7", 3'd4, 3'd4, 0, 4'd12, 0, 8'h96, 16'h0000);
    peek("R7 y high", 4'd12, 16'h965A);
    step("R8", 3'd3, 3'd5, 4'd12, 0, 0, 8'h81, 16'h0000);
    peek("R8 y low", 4'd12, 16'h9681);

    // R2 unused selectors address register 0; R3 op 7 writes nothing
    step("R2 sel6", 3'd6, 3'd6, 4'd5, 4'd5, 4'd5, 8'h00, 16'hBEEF);
    peek("R2 sel6 to r0", 4'd0, 16'hBEEF);
    step("R2 sel7", 3'd7, 3'd2, 4'd5, 4'd5, 4'd5, 8'h00, 16'h0000);
    peek("R2 sel7 to r0", 4'd0, 16'hBEF0);
    for (int s = 0; s < 8; s++) step("R3", 3'(s), 3'd7, 4'd9, 4'd7, 4'd12, 8'h55, 16'h7777);
    for (int s = 0; s < 8; s++) step("R3", 3'(s), 3'd0, 4'd9, 4'd7, 4'd12, 8'h55, 16'h7777);
    sweep("R3 hold");

    // random traffic
    void'($urandom(32'h5EED_0042));
    for (int t = 0; t < 3000; t++) begin
      step("R2 random", 3'($urandom), 3'($urandom), 4'($urandom), 4'($urandom),
           4'($urandom), 8'($urandom), 16'($urandom));
      if (t % 250 == 249) sweep("R10 random");
    end
    sweep("R10 final");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule